// File: doc/BRIEF.md
# Split-Range Huffman Sample Encoder

This block compresses a stream of 11-bit signed biomedical samples without loss. For each accepted sample it forms the wrapped first difference against the previous accepted sample and turns that difference into a short variable-length codeword. The codewords come from one small prefix-code table with sixteen value entries and one escape entry. A difference that fits the table's signed 4-bit range becomes a single output beat. A larger difference is split into segments, and the same table codes each segment on successive beats, so no wide table and no second table stage is ever built.

Samples enter on a valid/ready stream. Each output beat carries one left-aligned codeword with its length on a valid/ready stream. Packing codewords into fixed-width words is left to a downstream stage. A decoder rebuilds every sample bit for bit. It looks up each beat in the same table, reads the three segment beats that follow an escape, and adds each difference to its own copy of the predictor modulo 2^11.

A six-state sequencer controls the block. ST_IDLE holds no pending beat. ST_DIRECT presents the codeword of an in-range difference. ST_ESCAPE, ST_UPPER, ST_MIDDLE and ST_LOWER present the four beats of an out-of-range difference, in that order. The transitions are as follows. ACCEPT takes a sample from ST_IDLE, or from ST_DIRECT or ST_LOWER while the last beat is taken in the same cycle, and moves to ST_DIRECT or ST_ESCAPE according to the range check. ADVANCE moves one step along ESCAPE, UPPER, MIDDLE, LOWER when a beat is taken. DRAIN returns from ST_DIRECT or ST_LOWER to ST_IDLE when the last beat is taken and no sample is offered. HOLD keeps any state while its beat waits for out_ready.

Top module: `srh_encoder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1, and the predictor is zero: the first sample is coded as its difference from 0.
- R2: Each accepted sample is coded as d = (sample - previous accepted sample) modulo 2^11, and the sample then becomes the new predictor.
- R3: When d, read as 11-bit signed, lies in -8..+7, exactly one beat is emitted, starting the cycle after acceptance. It carries the table entry for the 4-bit pattern d[3:0].
- R4: Table (value: code, length): 0:00,2; +1:010,3; -1:011,3; +2:1000,4; -2:1001,4; +3:1010,4; -3:1011,4; +4:11000,5; -4:11001,5; +5:11010,5; -5:11011,5; +6:111000,6; -6:111001,6; +7:111010,6; -7:111011,6; escape:111100,6; -8:1111010,7. A 4-bit pattern indexes the table as a signed value.
- R5: Any other d produces exactly four beats, in this order: escape, then {0,d[10:8]}, then d[7:4], then d[3:0], each coded through the same table.
- R6: in_ready is 1 only in ST_IDLE, or on a DIRECT or LOWER beat while out_ready is 1. It is 0 throughout the escape, upper and middle beats.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_code and out_len stay unchanged in the next cycle.
- R8: out_code is left-aligned in 8 bits, every bit beyond out_len is 0, and out_len lies in 2..7.
- R9: Decoding the output stream with the table and the R5 segment order rebuilds every input sample exactly, including full-scale values and full-scale steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample accepted when high with in_valid |
| in_data | input | 11 | Signed input sample |
| out_valid | output | 1 | Codeword beat present |
| out_ready | input | 1 | Beat taken when high with out_valid |
| out_code | output | 8 | Left-aligned codeword |
| out_len | output | 4 | Codeword length in bits |

## Verification
A wrong predictor or difference register shows up at the first beat after the faulty acceptance. A decoder then rebuilds a wrong sample, and every later sample stays offset by the same error. A wrong sequencer state shows up within one beat. It appears as a segment out of order, an escape with too few or too many beats following it, in_ready raised in the middle of an escape group, or a codeword that changes while stalled. Each scenario therefore decodes every beat, checks the rebuilt sample at once, and checks in_ready on every beat.

// File: rtl/srh_pkg.sv
package srh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIRECT,
        ST_ESCAPE,
        ST_UPPER,
        ST_MIDDLE,
        ST_LOWER
    } seq_state_e;

    typedef enum logic [2:0] {
        SEL_DIRECT,
        SEL_ESCAPE,
        SEL_UPPER,
        SEL_MIDDLE,
        SEL_LOWER
    } sym_sel_e;

endpackage

// File: rtl/srh_delta.sv
// Wrapped first difference and table range check for an incoming sample.
module srh_delta #(
    parameter int SAMPLE_W = 11,
    parameter int SYM_W    = 4
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] pred,
    output logic [SAMPLE_W-1:0] diff,
    output logic                in_range
);
    localparam int TOP_W = SAMPLE_W - SYM_W + 1;

    logic [TOP_W-1:0] top_bits;

    always_comb begin
        diff     = sample - pred;
        top_bits = diff[SAMPLE_W-1:SYM_W-1];
        // fits a signed SYM_W index when every bit above it copies its sign
        in_range = (&top_bits) || (~|top_bits);
    end
endmodule

// File: rtl/srh_symsel.sv
// Chooses the table index for the beat currently presented.
module srh_symsel
    import srh_pkg::*;
#(
    parameter int SAMPLE_W = 11,
    parameter int SYM_W    = 4
) (
    input  logic [SAMPLE_W-1:0] diff,
    input  sym_sel_e            sel,
    output logic [SYM_W-1:0]    sym,
    output logic                esc
);
    localparam int HI_W = SAMPLE_W - 2 * SYM_W;

    logic [SYM_W-1:0] upper_sym;
    logic [SYM_W-1:0] middle_sym;
    logic [SYM_W-1:0] lower_sym;

    generate
        if (HI_W < SYM_W) begin : g_pad_upper
            assign upper_sym = {{(SYM_W - HI_W){1'b0}}, diff[SAMPLE_W-1 -: HI_W]};
        end else begin : g_full_upper
            assign upper_sym = diff[SAMPLE_W-1 -: SYM_W];
        end
    endgenerate

    assign middle_sym = diff[2*SYM_W-1 -: SYM_W];
    assign lower_sym  = diff[SYM_W-1:0];

    always_comb begin
        sym = lower_sym;
        esc = 1'b0;
        unique case (sel)
            SEL_DIRECT: sym = lower_sym;
            SEL_ESCAPE: esc = 1'b1;
            SEL_UPPER:  sym = upper_sym;
            SEL_MIDDLE: sym = middle_sym;
            SEL_LOWER:  sym = lower_sym;
            default:    sym = lower_sym;
        endcase
    end
endmodule

// File: rtl/srh_codebook.sv
// The one shared prefix-code table: sixteen signed values plus escape.
module srh_codebook #(
    parameter int SYM_W  = 4,
    parameter int CODE_W = 8,
    parameter int LEN_W  = 4
) (
    input  logic [SYM_W-1:0]  sym,
    input  logic              esc,
    output logic [CODE_W-1:0] code,
    output logic [LEN_W-1:0]  len
);
    always_comb begin
        code = '0;
        len  = '0;
        if (esc) begin
            code = 8'b1111_0000;
            len  = 4'd6;
        end else begin
            unique case (sym)
                4'h0: begin code = 8'b0000_0000; len = 4'd2; end
                4'h1: begin code = 8'b0100_0000; len = 4'd3; end
                4'hF: begin code = 8'b0110_0000; len = 4'd3; end
                4'h2: begin code = 8'b1000_0000; len = 4'd4; end
                4'hE: begin code = 8'b1001_0000; len = 4'd4; end
                4'h3: begin code = 8'b1010_0000; len = 4'd4; end
                4'hD: begin code = 8'b1011_0000; len = 4'd4; end
                4'h4: begin code = 8'b1100_0000; len = 4'd5; end
                4'hC: begin code = 8'b1100_1000; len = 4'd5; end
                4'h5: begin code = 8'b1101_0000; len = 4'd5; end
                4'hB: begin code = 8'b1101_1000; len = 4'd5; end
                4'h6: begin code = 8'b1110_0000; len = 4'd6; end
                4'hA: begin code = 8'b1110_0100; len = 4'd6; end
                4'h7: begin code = 8'b1110_1000; len = 4'd6; end
                4'h9: begin code = 8'b1110_1100; len = 4'd6; end
                4'h8: begin code = 8'b1111_0100; len = 4'd7; end
                default: begin code = '0; len = '0; end
            endcase
        end
    end
endmodule

// File: rtl/srh_sequencer.sv
// Beat sequencer: one beat for in-range differences, four for escapes.
module srh_sequencer
    import srh_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  logic     in_range,
    input  logic     out_ready,
    output logic     in_ready,
    output logic     out_valid,
    output logic     take,
    output sym_sel_e sel
);
    seq_state_e state_q;
    seq_state_e state_d;
    logic       last_beat;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        last_beat = (state_q == ST_DIRECT) || (state_q == ST_LOWER);
        in_ready  = (state_q == ST_IDLE) || (last_beat && out_ready);
        take      = in_valid && in_ready;
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) state_d = in_range ? ST_DIRECT : ST_ESCAPE;
            end
            ST_DIRECT, ST_LOWER: begin
                if (out_ready) begin
                    if (take) state_d = in_range ? ST_DIRECT : ST_ESCAPE;
                    else      state_d = ST_IDLE;
                end
            end
            ST_ESCAPE: if (out_ready) state_d = ST_UPPER;
            ST_UPPER:  if (out_ready) state_d = ST_MIDDLE;
            ST_MIDDLE: if (out_ready) state_d = ST_LOWER;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        out_valid = (state_q != ST_IDLE);
        sel       = SEL_DIRECT;
        unique case (state_q)
            ST_IDLE:   sel = SEL_DIRECT;
            ST_DIRECT: sel = SEL_DIRECT;
            ST_ESCAPE: sel = SEL_ESCAPE;
            ST_UPPER:  sel = SEL_UPPER;
            ST_MIDDLE: sel = SEL_MIDDLE;
            ST_LOWER:  sel = SEL_LOWER;
            default:   sel = SEL_DIRECT;
        endcase
    end
endmodule

// File: rtl/srh_encoder.sv
module srh_encoder
    import srh_pkg::*;
#(
    parameter int SAMPLE_W = 11,
    parameter int SYM_W    = 4,
    parameter int CODE_W   = 8,
    parameter int LEN_W    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [CODE_W-1:0]   out_code,
    output logic [LEN_W-1:0]    out_len
);
    logic [SAMPLE_W-1:0] pred_q;
    logic [SAMPLE_W-1:0] diff_q;
    logic [SAMPLE_W-1:0] diff_new;
    logic                new_in_range;
    logic                take;
    sym_sel_e            sel;
    logic [SYM_W-1:0]    sym;
    logic                esc;

    srh_delta #(.SAMPLE_W(SAMPLE_W), .SYM_W(SYM_W)) u_delta (
        .sample   (in_data),
        .pred     (pred_q),
        .diff     (diff_new),
        .in_range (new_in_range)
    );

    srh_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_range  (new_in_range),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .take      (take),
        .sel       (sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_q <= '0;
            diff_q <= '0;
        end else if (take) begin
            pred_q <= in_data;
            diff_q <= diff_new;
        end
    end

    srh_symsel #(.SAMPLE_W(SAMPLE_W), .SYM_W(SYM_W)) u_symsel (
        .diff (diff_q),
        .sel  (sel),
        .sym  (sym),
        .esc  (esc)
    );

    srh_codebook #(.SYM_W(SYM_W), .CODE_W(CODE_W), .LEN_W(LEN_W)) u_book (
        .sym  (sym),
        .esc  (esc),
        .code (out_code),
        .len  (out_len)
    );
endmodule

// File: rtl/srh_encoder_chk.sv
module srh_encoder_chk #(
    parameter int CODE_W = 8,
    parameter int LEN_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [CODE_W-1:0] out_code,
    input logic [LEN_W-1:0]  out_len
);
    logic [CODE_W-1:0] tail_bits;
    logic              esc_beat;

    assign tail_bits = out_code << out_len;
    assign esc_beat  = out_valid && (out_len == 4'd6) && (out_code == 8'hF0);

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_len)));

    // R8
    left_align_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (tail_bits == '0 && out_len >= 4'd2 && out_len <= 4'd7));

    // R6
    esc_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
        esc_beat |-> !in_ready);

    // R5
    esc_followed_chk: assert property (@(posedge clk) disable iff (rst)
        (esc_beat && out_ready) |=> (out_valid && !in_ready));

    // R3
    accept_emits_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);
endmodule

bind srh_encoder srh_encoder_chk #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_code  (out_code),
    .out_len   (out_len)
);

// File: tb/srh_encoder_bench.sv
module srh_encoder_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [10:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_code;
    logic [3:0]  out_len;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    logic [10:0] bpred = '0;
    logic [7:0]  ref_code [0:16];
    logic [3:0]  ref_len  [0:16];

    always #(CLK_PERIOD/2) clk = ~clk;

    srh_encoder u_srh_encoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_code(out_code), .out_len(out_len)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            check(1'b0, "watchdog", cycles, 100000);
            finish_up();
        end
    end

    function automatic int lookup(input logic [7:0] c, input logic [3:0] l);
        for (int k = 0; k < 17; k++)
            if (ref_code[k] == c && ref_len[k] == l) return k;
        return -1;
    endfunction

    // Takes one beat at the current negedge, optionally stalling first.
    task automatic take_beat(input int stall, output int idx, output logic rdy);
        logic [7:0] c0;
        logic [3:0] l0;
        check(out_valid === 1'b1, "R3 beat present", int'(out_valid), 1);
        if (stall > 0) begin
            out_ready = 1'b0;
            c0 = out_code;
            l0 = out_len;
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                check(out_valid && out_code == c0 && out_len == l0, "R7 stall hold",
                      int'(out_code), int'(c0));
            end
            out_ready = 1'b1;
            #1;
        end
        check((8'(out_code << out_len) == 8'h00) && out_len >= 2 && out_len <= 7,
              "R8 left aligned", int'(out_code), int'(out_len));
        idx = lookup(out_code, out_len);
        rdy = in_ready;
        @(negedge clk);
    endtask

    // Sends one sample, decodes its beats, checks R2..R9 on the way.
    task automatic run_sample(input logic [10:0] s, input int stall, input string tag);
        logic [10:0] d_exp;
        logic [10:0] d_got;
        logic [10:0] rebuilt;
        logic [3:0]  nib [0:2];
        int idx;
        logic rdy;
        bit far;
        d_exp = s - bpred;
        far = !((&d_exp[10:3]) || (~|d_exp[10:3]));
        @(negedge clk);
        check(in_ready === 1'b1, "R6 idle ready", int'(in_ready), 1);
        in_valid = 1'b1;
        in_data  = s;
        @(negedge clk);
        in_valid = 1'b0;
        take_beat(stall, idx, rdy);
        if (!far) begin
            check(idx == int'(d_exp[3:0]), {"R3 direct code ", tag}, idx, int'(d_exp[3:0]));
            check(rdy === 1'b1, "R6 last beat ready", int'(rdy), 1);
            d_got = {{7{4'(idx)}}, 4'(idx)} ;
            d_got = {{7{d_got[3]}}, d_got[3:0]};
        end else begin
            check(idx == 16, {"R5 escape first ", tag}, idx, 16);
            check(rdy === 1'b0, "R6 escape blocks", int'(rdy), 0);
            for (int b = 0; b < 3; b++) begin
                take_beat(stall, idx, rdy);
                check(idx >= 0 && idx < 16, "R4 segment code", idx, 0);
                nib[b] = 4'(idx);
                check(rdy === (b == 2), "R6 segment ready", int'(rdy), int'(b == 2));
            end
            check(nib[0][3] == 1'b0, "R5 upper pad", int'(nib[0]), 0);
            check(nib[0][2:0] == d_exp[10:8] && nib[1] == d_exp[7:4] && nib[2] == d_exp[3:0],
                  {"R5 segment order ", tag}, int'({nib[0][2:0], nib[1], nib[2]}), int'(d_exp));
            d_got = {nib[0][2:0], nib[1], nib[2]};
        end
        check(out_valid === 1'b0, {"R5 no extra beat ", tag}, int'(out_valid), 0);
        rebuilt = bpred + d_got;
        check(rebuilt == s, {"R9 rebuilt ", tag}, int'(rebuilt), int'(s));
        bpred = rebuilt;
    endtask

    task automatic test_reset();
        check(out_valid === 1'b0, "R1 reset valid", int'(out_valid), 0);
        check(in_ready === 1'b1, "R1 reset ready", int'(in_ready), 1);
        // first sample is 5: predictor zero gives difference +5 -> 11010
        run_sample(11'd5, 0, "R1 first");
    endtask

    task automatic test_table_values();
        // steps of every in-range difference, checking the R4 codes
        for (int v = -8; v <= 7; v++) run_sample(bpred + 11'(v), 0, "R4 sweep");
        // explicit codeword for zero difference
        @(negedge clk);
        in_valid = 1'b1; in_data = bpred;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_code == 8'h00 && out_len == 4'd2, "R4 zero code", int'(out_code), 0);
        @(negedge clk);
        check(out_code == 8'h00 || out_valid == 1'b0, "R4 zero drain", int'(out_valid), 0);
    endtask

    task automatic test_boundaries();
        run_sample(11'd0, 0, "R2 base");
        run_sample(11'h7F7, 0, "R3 minus9");   // -9 -> escape
        run_sample(11'h7FF, 0, "R3 plus8");    // +8 -> escape
        run_sample(11'h7F7, 0, "R3 minus8");   // -8 -> direct
        run_sample(11'h7FE, 0, "R3 plus7");    // +7 -> direct
        run_sample(11'h3FF, 0, "R9 fullpos");
        run_sample(11'h400, 0, "R9 fullneg");
        run_sample(11'h3FF, 0, "R9 fullstep");
    endtask

    task automatic test_stall();
        run_sample(11'h123, 3, "R7 esc stall");
        run_sample(11'h125, 2, "R7 direct stall");
    endtask

    task automatic test_back_to_back();
        logic [10:0] a;
        logic [10:0] b;
        a = bpred + 11'd3;
        b = a - 11'd2;
        @(negedge clk);
        in_valid = 1'b1; in_data = a;
        @(negedge clk);
        in_data = b;
        check(in_ready === 1'b1, "R6 back to back ready", int'(in_ready), 1);
        check(out_len == 4'd4 && out_code == 8'hA0, "R2 first of pair", int'(out_code), 8'hA0);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_len == 4'd4 && out_code == 8'h90, "R2 second of pair", int'(out_code), 8'h90);
        @(negedge clk);
        check(out_valid === 1'b0, "R3 pair drained", int'(out_valid), 0);
        bpred = b;
    endtask

    task automatic test_random();
        logic [10:0] s;
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 3) == 0) s = 11'($urandom);
            else s = bpred + 11'($urandom_range(0, 20)) - 11'd10;
            run_sample(s, (i % 7 == 0) ? 1 : 0, "R9 random");
        end
    endtask

    initial begin
        ref_code[0]  = 8'h00; ref_len[0]  = 2;
        ref_code[1]  = 8'h40; ref_len[1]  = 3;
        ref_code[15] = 8'h60; ref_len[15] = 3;
        ref_code[2]  = 8'h80; ref_len[2]  = 4;
        ref_code[14] = 8'h90; ref_len[14] = 4;
        ref_code[3]  = 8'hA0; ref_len[3]  = 4;
        ref_code[13] = 8'hB0; ref_len[13] = 4;
        ref_code[4]  = 8'hC0; ref_len[4]  = 5;
        ref_code[12] = 8'hC8; ref_len[12] = 5;
        ref_code[5]  = 8'hD0; ref_len[5]  = 5;
        ref_code[11] = 8'hD8; ref_len[11] = 5;
        ref_code[6]  = 8'hE0; ref_len[6]  = 6;
        ref_code[10] = 8'hE4; ref_len[10] = 6;
        ref_code[7]  = 8'hE8; ref_len[7]  = 6;
        ref_code[9]  = 8'hEC; ref_len[9]  = 6;
        ref_code[8]  = 8'hF4; ref_len[8]  = 7;
        ref_code[16] = 8'hF0; ref_len[16] = 6;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_table_values();
        test_boundaries();
        test_stall();
        test_back_to_back();
        test_random();
        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule